// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block holds the status word and control word of a stack-organised, extended-precision floating-point unit. Arithmetic units elsewhere report each exception they detect as a set of flag bits. A report may also carry a direction qualifier for the C1 condition bit. An internal-error strobe tells the block that the datapath reached an impossible state. The block merges every report into sticky flags, decides whether the report deserves attention under the current mask settings, and keeps the summary and busy bits that an instruction sequencer samples before it issues the next non-control instruction.

The control word is written directly by the sequencer. The status word is assembled from registered flags, registered condition codes and the stack-top pointer supplied by the register-stack logic. A clear command wipes the exception state in a single cycle.

Top module: `fpu_excstat_unit`

## Requirements
- R1: After reset the flags, stack-fault bit, summary bit, busy bit and condition codes are zero. The status word is packed as follows, from bit 0 upward: flags in bits 5:0, stack-fault in bit 6, summary in bit 7, C0 in bit 8, C1 in bit 9, C2 in bit 10, the `stk_top` input in bits 13:11, C3 in bit 14 and busy in bit 15.
- R2: A report ORs `rep_flags` into the sticky flags: invalid in bit 0, denormal in bit 1, zero-divide in bit 2, overflow in bit 3, underflow in bit 4 and precision in bit 5. Flags set earlier stay set.
- R3: When a report has `rep_stack` or precision (bit 5) set, C1 becomes `rep_c1`. In that case 1 means overflow or round-up and 0 means underflow or round-down. Any other report leaves C1 unchanged.
- R4: Summary and busy are set together, and only while a report is being merged, when any flag is set whose mask bit (the control-word bit in the same position) is 0. This uses the control word as it stood before that cycle. A control-word write on its own never changes them.
- R5: An internal-error strobe sets all six flags, the stack-fault bit, summary and busy in one cycle, and takes priority over a report in the same cycle.
- R6: `clr_exc` clears flags 5:0, the stack-fault bit, summary and busy in one cycle. It overrides a report or an internal error given in the same cycle.
- R7: `unmasked_pulse` is high for exactly the one cycle after a merged report whose own bits include an unmasked flag, or after an internal error. It is low otherwise.
- R8: A report with `rep_stack` set sets both the stack-fault bit and the invalid flag.
- R9: The control word resets to 0x033F. A write keeps bits 12:8 and 5:0 of `cw_wdata` and reads every other bit as 0.
- R10: `irq_pending` equals the summary bit at all times.
- R11: `cc_wr` loads C3..C0 from `cc_wdata[3:0]` (bit 3 is C3). A C1 value from a report in the same cycle takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rep_valid | input | 1 | Exception report strobe |
| rep_flags | input | 6 | Reported flag bits |
| rep_stack | input | 1 | Report is a stack fault |
| rep_c1 | input | 1 | Direction qualifier for C1 |
| int_err | input | 1 | Internal-error strobe |
| cw_wr | input | 1 | Control-word write enable |
| cw_wdata | input | 16 | Control-word write data |
| clr_exc | input | 1 | Clear-exceptions command |
| cc_wr | input | 1 | Condition-code write enable |
| cc_wdata | input | 4 | New C3..C0 |
| stk_top | input | 3 | Current stack-top pointer |
| status_word | output | 16 | Assembled status word |
| ctrl_word | output | 16 | Current control word |
| irq_pending | output | 1 | Pending floating-point interrupt |
| unmasked_pulse | output | 1 | One-cycle unmasked-exception indication |

## Verification
The bench unmasks a flag that is already set and checks that the summary bit stays clear until the next report. A design that re-evaluated the mask on every control write would raise the interrupt early. It then reports a masked flag and expects summary to rise without a pulse, which catches a design that tests only the new bits for the summary or tests all flags for the pulse. Round-up and round-down precision reports, stack overflow and underflow, and a condition-code write colliding with a C1 report check the direction handling. A clear that collides with a report or an internal error checks the priority order.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
  localparam int FLAG_W   = 6;
  localparam int SW_W     = 16;
  localparam int TOP_W    = 3;
  localparam int PREC_BIT = 5;
  localparam int INV_BIT  = 0;
  localparam logic [SW_W-1:0] CW_KEEP = 16'h1F3F;

  typedef struct packed {
    logic              busy;
    logic              c3;
    logic              c2;
    logic              c1;
    logic              c0;
    logic              es;
    logic              sf;
    logic [FLAG_W-1:0] flags;
  } stat_t;

  function automatic logic [SW_W-1:0] pack_sw(stat_t s, logic [TOP_W-1:0] top);
    return {s.busy, s.c3, top, s.c2, s.c1, s.c0, s.es, s.sf, s.flags};
  endfunction

  function automatic logic any_unmasked(logic [FLAG_W-1:0] f, logic [FLAG_W-1:0] m);
    return |(f & ~m);
  endfunction

  function automatic logic [FLAG_W-1:0] eff_flags(logic [FLAG_W-1:0] f, logic stk);
    logic [FLAG_W-1:0] r;
    r = f;
    if (stk) r[INV_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fpu_ctrl_word.sv
module fpu_ctrl_word
  import fpu_exc_pkg::*;
#(
  parameter logic [SW_W-1:0] RESET_VAL = 16'h033F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SW_W-1:0] wdata,
  output logic [SW_W-1:0] cw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cw <= RESET_VAL & CW_KEEP;
    else if (wr) cw <= wdata & CW_KEEP;
  end
endmodule

// File: rtl/fpu_flag_merge.sv
module fpu_flag_merge
  import fpu_exc_pkg::*;
(
  input  stat_t             cur,
  input  logic [FLAG_W-1:0] mask,
  input  logic              rep_valid,
  input  logic [FLAG_W-1:0] rep_flags,
  input  logic              rep_stack,
  input  logic              rep_c1,
  input  logic              int_err,
  input  logic              clr_exc,
  input  logic              cc_wr,
  input  logic [3:0]        cc_wdata,
  output stat_t             nxt,
  output logic              unmask_hit,
  output logic              c1_dir_evt
);
  logic              rep_fire;
  logic              ierr_fire;
  logic [FLAG_W-1:0] rep_eff;

  assign ierr_fire  = int_err && !clr_exc;
  assign rep_fire   = rep_valid && !clr_exc && !int_err;
  assign rep_eff    = eff_flags(rep_flags, rep_stack);
  assign c1_dir_evt = rep_fire && (rep_stack || rep_flags[PREC_BIT]);
  assign unmask_hit = ierr_fire || (rep_fire && any_unmasked(rep_eff, mask));

  always_comb begin
    nxt = cur;
    if (cc_wr) begin
      nxt.c3 = cc_wdata[3];
      nxt.c2 = cc_wdata[2];
      nxt.c1 = cc_wdata[1];
      nxt.c0 = cc_wdata[0];
    end
    if (clr_exc) begin
      nxt.flags = '0;
      nxt.sf    = 1'b0;
      nxt.es    = 1'b0;
      nxt.busy  = 1'b0;
    end else if (ierr_fire) begin
      nxt.flags = '1;
      nxt.sf    = 1'b1;
      nxt.es    = 1'b1;
      nxt.busy  = 1'b1;
    end else if (rep_fire) begin
      nxt.flags = cur.flags | rep_eff;
      nxt.sf    = cur.sf | rep_stack;
      if (c1_dir_evt) nxt.c1 = rep_c1;
      if (any_unmasked(nxt.flags, mask)) begin
        nxt.es   = 1'b1;
        nxt.busy = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpu_excstat_unit.sv
module fpu_excstat_unit
  import fpu_exc_pkg::*;
#(
  parameter logic [15:0] CW_RESET = 16'h033F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rep_valid,
  input  logic [5:0]  rep_flags,
  input  logic        rep_stack,
  input  logic        rep_c1,
  input  logic        int_err,
  input  logic        cw_wr,
  input  logic [15:0] cw_wdata,
  input  logic        clr_exc,
  input  logic        cc_wr,
  input  logic [3:0]  cc_wdata,
  input  logic [2:0]  stk_top,
  output logic [15:0] status_word,
  output logic [15:0] ctrl_word,
  output logic        irq_pending,
  output logic        unmasked_pulse
);
  stat_t stat_q;
  stat_t stat_d;
  logic  unmask_hit;
  logic  c1_dir_evt;

  fpu_ctrl_word #(.RESET_VAL(CW_RESET)) u_cw (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cw_wr),
    .wdata(cw_wdata),
    .cw   (ctrl_word)
  );

  fpu_flag_merge u_merge (
    .cur       (stat_q),
    .mask      (ctrl_word[FLAG_W-1:0]),
    .rep_valid (rep_valid),
    .rep_flags (rep_flags),
    .rep_stack (rep_stack),
    .rep_c1    (rep_c1),
    .int_err   (int_err),
    .clr_exc   (clr_exc),
    .cc_wr     (cc_wr),
    .cc_wdata  (cc_wdata),
    .nxt       (stat_d),
    .unmask_hit(unmask_hit),
    .c1_dir_evt(c1_dir_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q         <= '0;
      unmasked_pulse <= 1'b0;
    end else begin
      stat_q         <= stat_d;
      unmasked_pulse <= unmask_hit;
    end
  end

  assign status_word = pack_sw(stat_q, stk_top);
  assign irq_pending = stat_q.es;
endmodule

// File: rtl/fpu_excstat_sva.sv
module fpu_excstat_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        rep_valid,
  input logic [5:0]  rep_flags,
  input logic        rep_stack,
  input logic        rep_c1,
  input logic        int_err,
  input logic        clr_exc,
  input logic [15:0] status_word,
  input logic        irq_pending,
  input logic        unmasked_pulse,
  input logic        c1_dir_evt
);
  // R2: flags never drop without a clear
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_exc |=> ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0])));

  // R3: C1 takes the report direction
  p_c1_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !clr_exc && !int_err && (rep_stack || rep_flags[5])) |=> status_word[9] == $past(rep_c1));

  // R3: the internal direction event agrees with the port-level condition
  p_c1_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c1_dir_evt |-> (rep_valid && (rep_stack || rep_flags[5])));

  // R4: summary only moves when a report, error or clear is present
  p_es_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rep_valid && !int_err && !clr_exc) |=> status_word[7] == $past(status_word[7]));

  // R4: busy and summary travel together
  p_busy_es_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15] == status_word[7]);

  // R5: internal error saturates the exception state
  p_ierr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_err && !clr_exc) |=> (status_word[6:0] == 7'h7F && status_word[7] && status_word[15] && unmasked_pulse));

  // R6: clear empties the exception state
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_exc |=> (status_word[7:0] == 8'h00 && !status_word[15] && !unmasked_pulse));

  // R7: a pulse implies a pending interrupt
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unmasked_pulse |-> irq_pending);

  // R8: stack fault also marks invalid
  p_stack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_stack && !clr_exc && !int_err) |=> (status_word[6] && status_word[0]));
endmodule

bind fpu_excstat_unit fpu_excstat_sva u_sva (.*);

// File: tb/fpu_excstat_unit_tb.sv
module fpu_excstat_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rep_valid = 1'b0;
  logic [5:0]  rep_flags = '0;
  logic        rep_stack = 1'b0;
  logic        rep_c1 = 1'b0;
  logic        int_err = 1'b0;
  logic        cw_wr = 1'b0;
  logic [15:0] cw_wdata = '0;
  logic        clr_exc = 1'b0;
  logic        cc_wr = 1'b0;
  logic [3:0]  cc_wdata = '0;
  logic [2:0]  stk_top = '0;
  logic [15:0] status_word;
  logic [15:0] ctrl_word;
  logic        irq_pending;
  logic        unmasked_pulse;

  always #2 clk = ~clk;

  fpu_excstat_unit u_dut (.*);

  typedef struct {
    logic [15:0] sw;
    logic [15:0] cw;
    logic        pulse;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [5:0] m_fl = '0;
  logic m_sf = 0, m_es = 0, m_b = 0;
  logic [3:0] m_cc = '0;
  logic [15:0] m_cw = 16'h033F;

  task automatic op(input logic v, input logic [5:0] f, input logic st, input logic c1,
                    input logic ie, input logic cwr, input logic [15:0] cwd,
                    input logic clr, input logic ccw, input logic [3:0] ccd,
                    input logic [2:0] top, input string tag);
    exp_t e;
    logic pulse;
    logic [5:0] add;
    @(negedge clk);
    rep_valid = v; rep_flags = f; rep_stack = st; rep_c1 = c1; int_err = ie;
    cw_wr = cwr; cw_wdata = cwd; clr_exc = clr; cc_wr = ccw; cc_wdata = ccd; stk_top = top;
    pulse = 1'b0;
    add = f | {5'b0, st};
    if (ccw) m_cc = ccd;
    if (clr) begin
      m_fl = '0; m_sf = 0; m_es = 0; m_b = 0;
    end else if (ie) begin
      m_fl = 6'h3F; m_sf = 1; m_es = 1; m_b = 1; pulse = 1;
    end else if (v) begin
      m_fl = m_fl | add;
      m_sf = m_sf | st;
      if (st || f[5]) m_cc[1] = c1;
      if ((m_fl & ~m_cw[5:0]) != 0) begin m_es = 1; m_b = 1; end
      if ((add & ~m_cw[5:0]) != 0) pulse = 1;
    end
    if (cwr) m_cw = {3'b000, cwd[12:8], 2'b00, cwd[5:0]};
    e.sw = {m_b, m_cc[3], top, m_cc[2], m_cc[1], m_cc[0], m_es, m_sf, m_fl};
    e.cw = m_cw;
    e.pulse = pulse;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input logic [2:0] top, input string tag);
    op(0, 6'h00, 0, 0, 0, 0, 16'h0, 0, 0, 4'h0, top, tag);
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (status_word !== e.sw || ctrl_word !== e.cw || unmasked_pulse !== e.pulse ||
          irq_pending !== e.sw[7]) begin
        n_bad++;
        $display("FAIL %s: sw=%h cw=%h pulse=%b irq=%b expected sw=%h cw=%h pulse=%b irq=%b",
                 e.tag, status_word, ctrl_word, unmasked_pulse, irq_pending,
                 e.sw, e.cw, e.pulse, e.sw[7]);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3'd0, "R1 reset state");
    idle(3'd5, "R1 stack top field");
    // masked precision, round up then round down
    op(1, 6'h20, 0, 1, 0, 0, 16'h0, 0, 0, 4'h0, 3'd5, "R3 masked round-up sets C1");
    op(1, 6'h20, 0, 0, 0, 0, 16'h0, 0, 0, 4'h0, 3'd5, "R3 masked round-down clears C1");
    op(1, 6'h04, 0, 1, 0, 0, 16'h0, 0, 0, 4'h0, 3'd5, "R2 sticky zero-divide, C1 kept");
    // unmask zero-divide while it is already set: summary must not rise
    op(0, 6'h00, 0, 0, 0, 1, 16'h033B, 0, 0, 4'h0, 3'd5, "R4 control write alone");
    idle(3'd5, "R4 summary still clear");
    // masked denormal report now raises summary because zero-divide is unmasked
    op(1, 6'h02, 0, 0, 0, 0, 16'h0, 0, 0, 4'h0, 3'd5, "R4 R7 summary from old flag, no pulse");
    idle(3'd5, "R10 pending follows summary");
    op(1, 6'h08, 0, 0, 0, 0, 16'h0, 1, 0, 4'h0, 3'd5, "R6 clear beats report");
    op(0, 6'h00, 0, 0, 0, 1, 16'h033F, 0, 0, 4'h0, 3'd1, "R9 restore mask");
    op(1, 6'h00, 1, 1, 0, 0, 16'h0, 0, 0, 4'h0, 3'd1, "R8 R3 stack overflow");
    op(1, 6'h00, 1, 0, 0, 0, 16'h0, 0, 0, 4'h0, 3'd1, "R3 stack underflow");
    op(0, 6'h00, 0, 0, 0, 0, 16'h0, 0, 1, 4'hA, 3'd1, "R11 condition write");
    op(1, 6'h20, 0, 0, 0, 0, 16'h0, 0, 1, 4'hF, 3'd1, "R11 report C1 overrides write");
    op(1, 6'h08, 0, 1, 0, 0, 16'h0, 0, 0, 4'h0, 3'd1, "R3 non-direction report keeps C1");
    op(0, 6'h00, 0, 0, 0, 1, 16'hFFFF, 0, 0, 4'h0, 3'd1, "R9 write mask of control word");
    op(0, 6'h00, 0, 0, 0, 1, 16'h1F3E, 1, 0, 4'h0, 3'd1, "R9 R6 unmask invalid with clear");
    op(1, 6'h01, 0, 0, 0, 0, 16'h0, 0, 0, 4'h0, 3'd7, "R7 R4 unmasked invalid pulses");
    idle(3'd7, "R7 pulse lasts one cycle");
    op(1, 6'h01, 1, 0, 0, 0, 16'h0, 0, 0, 4'h0, 3'd7, "R7 R8 stack fault unmasked via invalid");
    op(0, 6'h00, 0, 0, 0, 0, 16'h0, 1, 0, 4'h0, 3'd7, "R6 clear");
    op(1, 6'h10, 0, 0, 1, 0, 16'h0, 0, 0, 4'h0, 3'd2, "R5 internal error beats report");
    idle(3'd2, "R5 state held, pulse gone");
    op(0, 6'h00, 0, 0, 1, 0, 16'h0, 1, 0, 4'h0, 3'd2, "R6 clear beats internal error");
    op(0, 6'h00, 0, 0, 0, 1, 16'h033F, 0, 0, 4'h0, 3'd2, "R9 all masked");
    op(1, 6'h3F, 0, 1, 0, 0, 16'h0, 0, 0, 4'h0, 3'd2, "R2 R4 all flags masked, no summary");
    idle(3'd3, "R1 idle");
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule